// File: doc/BRIEF.md
# Register File Window Address Translator

This block sits on the direct-address path of a CPU register file. It turns an 8-bit direct address into a 16-bit internal memory address. A window-selection register chooses one aligned slice of a larger memory region. That slice replaces the top 32, 64 or 128 direct addresses. Addresses below the active window, and every address while windowing is off, pass through with the high byte set to zero.

The 7-bit selection field encodes the window size and the window number together. The highest set bit among field bits 6, 5 and 4 picks the size, and the bits below it give the number. The most significant bit of the register is a bus-hold enable flag. It goes straight out as its own output and does not affect translation. The register is written through the ordinary direct-write path at its own direct address. It can also be loaded as a whole through a separate port, and its value is always visible, so a save-all / restore-all sequence can capture and put back the whole register.

Translation is purely combinational from the current register value. A write or load therefore changes the mapping from the first access after the clock edge that stores it.

Top module: `rfwin_xlate`

## Requirements
- R1: While reset is held and after it is released, the selection register reads 00h, `holdEn` is 0, and `memAddr` equals `{8'h00, dirAddr}` for every direct address.
- R2: With `wrEn` high, `loadEn` low and `dirAddr` equal to 14h, the register takes `wrData` at the rising clock edge. A write pulse at any other direct address leaves the register and the translation unchanged.
- R3: With `loadEn` high, the register takes `loadData` at the rising clock edge. This load wins over a write in the same cycle. `selValue` always shows the stored byte, so saving that byte and loading it back restores the original mapping.
- R4: `holdEn` equals register bit 7. Toggling bit 7 leaves `memAddr` identical for every direct address.
- R5: When register bits 6:4 are all zero, `memAddr` equals `{8'h00, dirAddr}` for all 256 direct addresses.
- R6: When bit 6 is set, the window is 32 bytes and covers direct E0h–FFh. For those addresses `memAddr = 1800h + bits[5:0]*32 + (dirAddr mod 32)`. For example, register 7Ah with direct E0h gives 1F40h, and register 7Bh with direct E0h gives 1F60h.
- R7: When bit 6 is clear and bit 5 is set, the window is 64 bytes and covers C0h–FFh. For those addresses `memAddr = 1800h + bits[4:0]*64 + (dirAddr mod 64)`. For example, register 3Dh gives 1F40h at C0h and 1F60h at E0h.
- R8: When bits 6:5 are clear and bit 4 is set, the window is 128 bytes and covers 80h–FFh. For those addresses `memAddr = 1800h + bits[3:0]*128 + (dirAddr mod 128)`. For example, register 1Eh gives 1F40h at C0h and 1F60h at E0h.
- R9: Direct addresses below the start of the active window, including 14h, translate to `{8'h00, dirAddr}`.
- R10: For every even direct address `a`, the translation of `a+1` equals the translation of `a` plus one, so both bytes of a word access land in the same slice.
- R11: A new register value does not affect `selValue` or `memAddr` before the storing edge. It applies from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| dirAddr | input | 8 | Direct register-file address |
| wrEn | input | 1 | Direct write strobe. It writes the register when `dirAddr` is 14h |
| wrData | input | 8 | Direct write data |
| loadEn | input | 1 | Whole-register restore strobe |
| loadData | input | 8 | Restore data |
| selValue | output | 8 | Current register contents, used for save |
| memAddr | output | 16 | Translated memory address |
| holdEn | output | 1 | Bus-hold enable flag (register bit 7) |

## Verification
The assertions assume that `dirAddr`, `wrEn`, `loadEn` and both data buses are stable around each rising edge. They also assume that any value on the data buses is a legal register value, so no encoding is excluded. The bench changes inputs only at the falling edge, or between edges while no strobe is active. It sweeps every register byte, including all bit-7 settings and all disabled codes, against every direct address. Because every code is a legal input, the checker relates outputs to register bits for every value instead of limiting the stimulus.

// File: rtl/rfwin_pkg.sv
package rfwin_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic selWrite;
    logic selLoad;
  } rfwin_strobe_t;

  // Number of window sizes, smallest window as a power of two
  localparam int WIN_LEVELS    = 3;
  localparam int MIN_WIN_SHIFT = 5;

endpackage

// File: rtl/rfwin_ctrl.sv
module rfwin_ctrl
  import rfwin_pkg::*;
#(
  parameter int                 DIR_W    = 8,
  parameter logic [DIR_W-1:0]   SEL_ADDR = 8'h14
) (
  input  logic             wrEn,
  input  logic [DIR_W-1:0] dirAddr,
  input  logic             loadEn,
  output rfwin_strobe_t    strobe
);

  logic addrHit;

  assign addrHit = (dirAddr == SEL_ADDR);

  always_comb begin
    strobe          = '0;
    // restore path has priority over an ordinary write
    strobe.selLoad  = loadEn;
    strobe.selWrite = wrEn && addrHit && !loadEn;
  end

endmodule

// File: rtl/rfwin_dp.sv
module rfwin_dp
  import rfwin_pkg::*;
#(
  parameter int               DIR_W       = 8,
  parameter int               MEM_W       = 16,
  parameter logic [MEM_W-1:0] REGION_BASE = 16'h1800
) (
  input  logic             clk,
  input  logic             rstN,
  input  rfwin_strobe_t    strobe,
  input  logic [DIR_W-1:0] wrData,
  input  logic [DIR_W-1:0] loadData,
  input  logic [DIR_W-1:0] dirAddr,
  output logic [DIR_W-1:0] selQ,
  output logic [MEM_W-1:0] memAddr,
  output logic             holdEn
);

  localparam int HOLD_BIT  = DIR_W - 1;
  localparam int FIELD_TOP = DIR_W - 2;

  logic [DIR_W-1:0] selNext;
  logic [WIN_LEVELS-1:0] levelSel;
  logic [WIN_LEVELS-1:0] levelInRange;
  logic [MEM_W-1:0] candAddr [WIN_LEVELS];
  logic [MEM_W-1:0] passAddr;

  always_comb begin
    selNext = selQ;
    if (strobe.selLoad)       selNext = loadData;
    else if (strobe.selWrite) selNext = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selQ <= '0;
    else       selQ <= selNext;
  end

  assign holdEn   = selQ[HOLD_BIT];
  assign passAddr = {{(MEM_W-DIR_W){1'b0}}, dirAddr};

  // One candidate translation per window size; level 0 is the smallest
  for (genvar g = 0; g < WIN_LEVELS; g++) begin : g_level
    localparam int SH     = MIN_WIN_SHIFT + g;
    localparam int BITPOS = FIELD_TOP - g;
    localparam logic [DIR_W-1:0] WIN_LO   = DIR_W'((1 << DIR_W) - (1 << SH));
    localparam logic [DIR_W-1:0] OFS_MASK = DIR_W'((1 << SH) - 1);

    logic [MEM_W-1:0] winBase;

    assign levelSel[g]     = selQ[BITPOS];
    assign levelInRange[g] = (dirAddr >= WIN_LO);
    assign winBase         = MEM_W'(selQ[BITPOS-1:0]) << SH;
    assign candAddr[g]     = REGION_BASE + winBase + MEM_W'(dirAddr & OFS_MASK);
  end

  // Leading one of the size field picks the level
  always_comb begin
    logic found;
    found   = 1'b0;
    memAddr = passAddr;
    for (int g = 0; g < WIN_LEVELS; g++) begin
      if (!found && levelSel[g]) begin
        found = 1'b1;
        if (levelInRange[g]) memAddr = candAddr[g];
      end
    end
  end

endmodule

// File: rtl/rfwin_xlate.sv
module rfwin_xlate
  import rfwin_pkg::*;
#(
  parameter int                DIR_W       = 8,
  parameter int                MEM_W       = 16,
  parameter logic [DIR_W-1:0]  SEL_ADDR    = 8'h14,
  parameter logic [MEM_W-1:0]  REGION_BASE = 16'h1800
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIR_W-1:0] dirAddr,
  input  logic             wrEn,
  input  logic [DIR_W-1:0] wrData,
  input  logic             loadEn,
  input  logic [DIR_W-1:0] loadData,
  output logic [DIR_W-1:0] selValue,
  output logic [MEM_W-1:0] memAddr,
  output logic             holdEn
);

  rfwin_strobe_t strobe;

  rfwin_ctrl #(.DIR_W(DIR_W), .SEL_ADDR(SEL_ADDR)) ctrl_i (
    .wrEn    (wrEn),
    .dirAddr (dirAddr),
    .loadEn  (loadEn),
    .strobe  (strobe)
  );

  rfwin_dp #(.DIR_W(DIR_W), .MEM_W(MEM_W), .REGION_BASE(REGION_BASE)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .loadData (loadData),
    .dirAddr  (dirAddr),
    .selQ     (selValue),
    .memAddr  (memAddr),
    .holdEn   (holdEn)
  );

endmodule

// File: rtl/rfwin_xlate_chk.sv
module rfwin_xlate_chk #(
  parameter int               DIR_W    = 8,
  parameter int               MEM_W    = 16,
  parameter logic [DIR_W-1:0] SEL_ADDR = 8'h14
) (
  input logic             clk,
  input logic             rstN,
  input logic [DIR_W-1:0] dirAddr,
  input logic             wrEn,
  input logic [DIR_W-1:0] wrData,
  input logic             loadEn,
  input logic [DIR_W-1:0] loadData,
  input logic [DIR_W-1:0] selValue,
  input logic [MEM_W-1:0] memAddr,
  input logic             holdEn
);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |=> selValue == '0); // R1

  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !loadEn && dirAddr == SEL_ADDR) |=> selValue == $past(wrData)); // R2

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> selValue == $past(loadData)); // R3

  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !(wrEn && dirAddr == SEL_ADDR)) |=> $stable(selValue)); // R11

  AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    holdEn == selValue[DIR_W-1]); // R4

  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (selValue[DIR_W-2 -: 3] == 3'b000) |-> memAddr == MEM_W'(dirAddr)); // R5

  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !dirAddr[DIR_W-1] |-> memAddr == MEM_W'(dirAddr)); // R9

endmodule

bind rfwin_xlate rfwin_xlate_chk #(.DIR_W(DIR_W), .MEM_W(MEM_W), .SEL_ADDR(SEL_ADDR)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .dirAddr  (dirAddr),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .loadEn   (loadEn),
  .loadData (loadData),
  .selValue (selValue),
  .memAddr  (memAddr),
  .holdEn   (holdEn)
);

// File: tb/rfwin_xlate_tb_top.sv
`timescale 1ns/1ps
module rfwin_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  dirAddr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        loadEn = 1'b0;
  logic [7:0]  loadData = '0;
  logic [7:0]  selValue;
  logic [15:0] memAddr;
  logic        holdEn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rfwin_xlate dut_i (
    .clk(clk), .rstN(rstN), .dirAddr(dirAddr), .wrEn(wrEn), .wrData(wrData),
    .loadEn(loadEn), .loadData(loadData), .selValue(selValue),
    .memAddr(memAddr), .holdEn(holdEn)
  );

  function automatic logic [15:0] expAddr(input logic [7:0] s, input logic [7:0] d);
    int sh;
    int num;
    int lo;
    sh = 0;
    if (s[6])      begin sh = 5; num = int'(s[5:0]); end
    else if (s[5]) begin sh = 6; num = int'(s[4:0]); end
    else if (s[4]) begin sh = 7; num = int'(s[3:0]); end
    if (sh == 0) return {8'h00, d};
    lo = 256 - (1 << sh);
    if (int'(d) < lo) return {8'h00, d};
    return 16'(32'h1800 + (num << sh) + (int'(d) & ((1 << sh) - 1)));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeSel(input logic [7:0] v);
    logic [7:0] old;
    @(negedge clk);
    old = selValue;
    dirAddr = 8'h14; wrData = v; wrEn = 1'b1;
    #1 check("R11 before edge", 32'(selValue), 32'(old));
    @(negedge clk);
    wrEn = 1'b0;
    check("R2 write stored", 32'(selValue), 32'(v));
  endtask

  task automatic probe(input string req, input logic [7:0] d, input logic [15:0] e);
    dirAddr = d;
    #1 check(req, 32'(memAddr), 32'(e));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] saved;
    logic [15:0] prev;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 sel in reset", 32'(selValue), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 sel after reset", 32'(selValue), 32'h0);
    check("R1 hold after reset", 32'(holdEn), 32'h0);
    probe("R1 pass E0", 8'hE0, 16'h00E0);
    probe("R1 pass 80", 8'h80, 16'h0080);

    // Worked encodings
    writeSel(8'h7A); probe("R6 7A/E0", 8'hE0, 16'h1F40);
    writeSel(8'h7B); probe("R6 7B/E0", 8'hE0, 16'h1F60);
    writeSel(8'h3D); probe("R7 3D/C0", 8'hC0, 16'h1F40);
                     probe("R7 3D/E0", 8'hE0, 16'h1F60);
    writeSel(8'h1E); probe("R8 1E/C0", 8'hC0, 16'h1F40);
                     probe("R8 1E/E0", 8'hE0, 16'h1F60);
    probe("R9 sel addr", 8'h14, 16'h0014);

    // R2 write at another address is ignored
    writeSel(8'h7A);
    @(negedge clk);
    dirAddr = 8'h15; wrData = 8'h00; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R2 stray write sel", 32'(selValue), 32'h7A);
    probe("R2 stray write map", 8'hE0, 16'h1F40);

    // R3 load priority and save/restore
    @(negedge clk);
    dirAddr = 8'h14; wrData = 8'h1E; wrEn = 1'b1; loadData = 8'h3D; loadEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; loadEn = 1'b0;
    check("R3 load priority", 32'(selValue), 32'h3D);
    saved = selValue;
    writeSel(8'hF0);
    @(negedge clk);
    loadData = saved; loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    check("R3 restore", 32'(selValue), 32'h3D);
    probe("R3 restored map", 8'hC0, 16'h1F40);

    // Exhaustive sweep: all register bytes x all direct addresses
    for (int s = 0; s < 256; s++) begin
      writeSel(8'(s));
      check("R4 hold flag", 32'(holdEn), 32'(s >> 7));
      prev = '0;
      for (int d = 0; d < 256; d++) begin
        dirAddr = 8'(d);
        #1;
        if (s[6:4] == 3'b000)
          check("R5 disabled pass", 32'(memAddr), 32'(d));
        else if (s[6])
          check("R6 32-byte map", 32'(memAddr), 32'(expAddr(8'(s), 8'(d))));
        else if (s[5])
          check("R7 64-byte map", 32'(memAddr), 32'(expAddr(8'(s), 8'(d))));
        else
          check("R8 128-byte map", 32'(memAddr), 32'(expAddr(8'(s), 8'(d))));
        if (s >= 128)
          check("R4 bit7 no effect", 32'(memAddr), 32'(expAddr(8'(s - 128), 8'(d))));
        if (d < 128)
          check("R9 below window", 32'(memAddr), 32'(d));
        if (d[0])
          check("R10 word pair", 32'(memAddr), 32'(prev + 16'd1));
        prev = memAddr;
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule